// File: doc/BRIEF.md
# Prioritised Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and presents a single 4-bit interrupt level code to a processor. Each request line is reflected into its own bit of a 16-bit pending word. The bit positions are scattered, not in source order. A software-written 16-bit enable mask gates that word. Among the sources that are both pending and enabled, the one with the lowest priority number wins. Source index k carries priority number k. The block drives the winner's priority XOR 15 as the level code. When no source qualifies, the internal level is 15 and the code is 0.

A small register window sits on a simple 16-bit bus (select, write strobe, 6-bit byte address, write data, combinational read data). The window holds the enable mask, a general-purpose 16-bit output port, a power-off control and a constant identification value. A write to the power-off control with bit 0 set produces a one-cycle shutdown request pulse.

Top module: `prio_irq_encoder`

## Requirements
- R1: Request input `irq_req[s]` sets pending bit p(s). The mapping is s0→11, s1→9, s2→8, s3→12, s4→10, s5→6, s6→5, s7→4, s8→7, s9→14, s10→13, s11→0, s12→15. A source qualifies only when its request is high and mask bit p(s) is 1. Mask bits 1, 2 and 3 enable nothing.
- R2: When several sources qualify, the lowest source index wins, because source index s has priority number s.
- R3: When no source qualifies, `irl_code` is 4'h0.
- R4: `irl_code` equals the winning source index XOR 4'hF (source 0 gives 4'hF, source 12 gives 4'h3). It is registered. It reflects the requests present at a rising edge and the mask value held before that edge. A mask write therefore shows in `irl_code` one edge after the mask register takes the new value.
- R5: Offset 0x00 is the mask register. A write stores `bus_wdata` on the clock edge, a read returns the stored value, and reset clears it to 0.
- R6: Offset 0x32 always reads 16'h0010, and writes to it change nothing. Offset 0x30 always reads 16'h0000.
- R7: A write to offset 0x30 with `bus_wdata[0]`=1 makes `pwr_off_req` high for exactly the cycle after the write edge. A write with bit 0 clear gives no pulse.
- R8: Offset 0x36 is the output port. A write stores the data, which drives `out_port` and reads back. Reset clears it to 0.
- R9: A read of any other offset, including odd addresses, returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 13 | Level-sensitive request lines, index = source/priority number |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset inside the 64-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| out_port | output | 16 | General-purpose output register |
| irl_code | output | 4 | Encoded interrupt level to the processor |
| pwr_off_req | output | 1 | One-cycle power-off request pulse |

## Verification
On every cycle the assertions check the following. An idle qualified word yields a zero code, and an enabled source 0 yields 4'hF. The mask and output-port registers change only through writes to their own offsets, and they take the written data. The power-off pulse only follows a qualifying write. The constant and unmapped read values hold. The scattered bit mapping and the choice of winner under many mixed request and mask patterns can only be shown by the bench's vector table. The same holds for the exact one-edge lag after a mask write, and for the absence of a pulse when bit 0 is clear.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int NSRC = 13;
  localparam int DW   = 16;
  localparam int AW   = 6;
  localparam int LW   = 4;

  localparam logic [AW-1:0] OFF_MASK = 6'h00;
  localparam logic [AW-1:0] OFF_PWR  = 6'h30;
  localparam logic [AW-1:0] OFF_VER  = 6'h32;
  localparam logic [AW-1:0] OFF_OUT  = 6'h36;

  localparam logic [DW-1:0] VER_VAL  = 16'h0010;
  localparam logic [LW-1:0] IDLE_LVL = 4'hF;

  // Position of a source's bit in the pending word and in the mask.
  function automatic int src_bit(input int s);
    case (s)
      0:       return 11;
      1:       return 9;
      2:       return 8;
      3:       return 12;
      4:       return 10;
      5:       return 6;
      6:       return 5;
      7:       return 4;
      8:       return 7;
      9:       return 14;
      10:      return 13;
      11:      return 0;
      12:      return 15;
      default: return 1;
    endcase
  endfunction

  // Lowest-numbered qualifying source, inverted; idle level 15 -> code 0.
  function automatic logic [LW-1:0] pick_code(input logic [DW-1:0] qual);
    logic [LW-1:0] lvl;
    lvl = IDLE_LVL;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (qual[src_bit(s)]) lvl = LW'(s);
    end
    return lvl ^ IDLE_LVL;
  endfunction
endpackage

// File: rtl/irq_mon_map.sv
module irq_mon_map
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int D_W   = DW
) (
  input  logic [N_SRC-1:0] req,
  output logic [D_W-1:0]   mon
);
  always_comb begin
    mon = '0;
    for (int s = 0; s < N_SRC; s++) begin
      mon[src_bit(s)] = req[s];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_enc_pkg::*;
#(
  parameter int D_W = DW,
  parameter int L_W = LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [D_W-1:0] mon,
  input  logic [D_W-1:0] mask,
  output logic           qual_any,
  output logic [L_W-1:0] code_q
);
  logic [D_W-1:0] qual;

  assign qual     = mon & mask;
  assign qual_any = |qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= L_W'(pick_code(DW'(qual)));
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_enc_pkg::*;
#(
  parameter int D_W = DW,
  parameter int A_W = AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           wr,
  input  logic [A_W-1:0] addr,
  input  logic [D_W-1:0] wdata,
  output logic [D_W-1:0] rdata,
  output logic [D_W-1:0] mask_q,
  output logic [D_W-1:0] outp_q,
  output logic           pwr_q
);
  logic wr_mask, wr_out, wr_pwr_go;

  assign wr_mask   = sel && wr && (addr == A_W'(OFF_MASK));
  assign wr_out    = sel && wr && (addr == A_W'(OFF_OUT));
  assign wr_pwr_go = sel && wr && (addr == A_W'(OFF_PWR)) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      outp_q <= '0;
      pwr_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_out)  outp_q <= wdata;
      pwr_q <= wr_pwr_go;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_W'(OFF_MASK))     rdata = mask_q;
    else if (addr == A_W'(OFF_OUT)) rdata = outp_q;
    else if (addr == A_W'(OFF_VER)) rdata = D_W'(VER_VAL);
  end
endmodule

// File: rtl/prio_irq_encoder.sv
module prio_irq_encoder
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int D_W   = DW,
  parameter int A_W   = AW,
  parameter int L_W   = LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [A_W-1:0]   bus_addr,
  input  logic [D_W-1:0]   bus_wdata,
  output logic [D_W-1:0]   bus_rdata,
  output logic [D_W-1:0]   out_port,
  output logic [L_W-1:0]   irl_code,
  output logic             pwr_off_req
);
  logic [D_W-1:0] mon_word;
  logic [D_W-1:0] mask_word;
  logic           qual_any;

  irq_mon_map #(.N_SRC(N_SRC), .D_W(D_W)) u_map (
    .req (irq_req),
    .mon (mon_word)
  );

  irq_regfile #(.D_W(D_W), .A_W(A_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .mask_q (mask_word),
    .outp_q (out_port),
    .pwr_q  (pwr_off_req)
  );

  irq_prio_enc #(.D_W(D_W), .L_W(L_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon      (mon_word),
    .mask     (mask_word),
    .qual_any (qual_any),
    .code_q   (irl_code)
  );
endmodule

// File: rtl/prio_irq_encoder_chk.sv
module prio_irq_encoder_chk
  import irq_enc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [12:0]   irq_req,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic [15:0]   out_port,
  input logic [3:0]    irl_code,
  input logic          pwr_off_req,
  input logic [15:0]   mask_word,
  input logic          qual_any
);
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_any |=> irl_code == 4'h0);

  p_src0_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[0] && mask_word[11]) |=> irl_code == 4'hF);

  p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFF_MASK) |=> mask_word == $past(bus_wdata));

  p_mask_only_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_word) |-> $past(bus_sel && bus_wr && bus_addr == OFF_MASK));

  p_ver_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_VER) |-> bus_rdata == VER_VAL);

  p_pwr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> $past(bus_sel && bus_wr && bus_addr == OFF_PWR && bus_wdata[0]));

  p_out_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFF_OUT) |=> out_port == $past(bus_wdata));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFF_MASK && bus_addr != OFF_OUT && bus_addr != OFF_VER)
      |-> bus_rdata == 16'h0000);
endmodule

bind prio_irq_encoder prio_irq_encoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_req     (irq_req),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .out_port    (out_port),
  .irl_code    (irl_code),
  .pwr_off_req (pwr_off_req),
  .mask_word   (mask_word),
  .qual_any    (qual_any)
);

// File: tb/prio_irq_encoder_bench.sv
`timescale 1ns/1ps
module prio_irq_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_req = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] out_port;
  logic [3:0]  irl_code;
  logic        pwr_off_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  prio_irq_encoder u_prio_irq_encoder (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .out_port(out_port), .irl_code(irl_code),
    .pwr_off_req(pwr_off_req)
  );

  // vector: {req[12:0], mask[15:0], expected code[3:0]}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {13'h1FFF, 16'hFFFF, 4'hF},  // R2 all pending -> source 0
    {13'h1FFF, 16'h0000, 4'h0},  // R3 everything masked
    {13'h1FFE, 16'hFFFF, 4'hE},  // R2 source 1 wins
    {13'h0001, 16'hF7FF, 4'h0},  // R1 source 0 needs mask bit 11
    {13'h1000, 16'h8000, 4'h3},  // R1 source 12 on bit 15
    {13'h0800, 16'h0001, 4'h4},  // R1 source 11 on bit 0
    {13'h0220, 16'hFFFF, 4'hA},  // R2 source 5 beats 9
    {13'h0220, 16'h4000, 4'h6},  // R1 only source 9 enabled (bit 14)
    {13'h0018, 16'h1400, 4'hC},  // R2 source 3 beats 4
    {13'h0100, 16'h0080, 4'h7},  // R1 source 8 on bit 7
    {13'h0004, 16'h000E, 4'h0},  // R1 bits 1..3 enable nothing
    {13'h00C0, 16'h0010, 4'h8}   // R1 source 7 on bit 4 only
  };

  // Independent model: scan sources by priority, using bench's own position list.
  localparam int POS [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
  function automatic logic [3:0] model(input logic [12:0] r, input logic [15:0] m);
    for (int s = 0; s < 13; s++)
      if (r[s] && m[POS[s]]) return 4'(15 - s);
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // reset state (R5, R8)
    check("R3 reset code", {12'h0, irl_code}, 16'h0);
    check("R8 reset out_port", out_port, 16'h0);
    check("R7 reset pulse", {15'h0, pwr_off_req}, 16'h0);
    rst_n = 1'b1;
    bread(6'h00, rd);
    check("R5 reset mask", rd, 16'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [12:0] r; logic [15:0] m; logic [3:0] e;
      {r, m, e} = VEC[i];
      bwrite(6'h00, m);
      @(negedge clk); irq_req = r;
      @(negedge clk); @(negedge clk);
      check($sformatf("R4 vector %0d", i), {12'h0, irl_code}, {12'h0, e});
      check($sformatf("R4 model %0d", i), {12'h0, irl_code}, {12'h0, model(r, m)});
    end

    // R4 latency: request change visible after exactly one edge
    bwrite(6'h00, 16'hFFFF);
    @(negedge clk); irq_req = 13'h0;
    @(negedge clk);
    check("R3 cleared after one edge", {12'h0, irl_code}, 16'h0);
    irq_req = 13'h0040;           // source 6 -> code 9
    @(negedge clk);
    check("R4 request after one edge", {12'h0, irl_code}, 16'h0009);
    // R4 mask latency: one extra edge after mask register updates
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R4 mask lag old code", {12'h0, irl_code}, 16'h0009);
    @(negedge clk);
    check("R4 mask lag new code", {12'h0, irl_code}, 16'h0000);
    bread(6'h00, rd);
    check("R5 mask readback", rd, 16'h0000);
    bwrite(6'h00, 16'hA5C3);
    bread(6'h00, rd);
    check("R5 mask readback pattern", rd, 16'hA5C3);

    // R6 version and power-off reads
    bread(6'h32, rd);
    check("R6 version read", rd, 16'h0010);
    bwrite(6'h32, 16'hFFFF);
    bread(6'h32, rd);
    check("R6 version write ignored", rd, 16'h0010);
    bread(6'h30, rd);
    check("R6 poweroff reads zero", rd, 16'h0000);

    // R7 pulse timing
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h30; bus_wdata = 16'h0001;
    #1 check("R7 no pulse before edge", {15'h0, pwr_off_req}, 16'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R7 pulse after edge", {15'h0, pwr_off_req}, 16'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {15'h0, pwr_off_req}, 16'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h30; bus_wdata = 16'hFFFE;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R7 bit0 clear no pulse", {15'h0, pwr_off_req}, 16'h0);

    // R8 output port
    bwrite(6'h36, 16'h3C5A);
    check("R8 out_port drive", out_port, 16'h3C5A);
    bread(6'h36, rd);
    check("R8 out_port readback", rd, 16'h3C5A);

    // R9 unmapped offsets
    bread(6'h10, rd);
    check("R9 unmapped 0x10", rd, 16'h0000);
    bread(6'h01, rd);
    check("R9 odd address", rd, 16'h0000);
    bwrite(6'h3E, 16'hFFFF);
    bread(6'h3E, rd);
    check("R9 unmapped after write", rd, 16'h0000);
    check("R9 write left out_port", out_port, 16'h3C5A);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule